// File: doc/BRIEF.md
# Oversampling Deskew Phase Selector

This block chooses, for every serial receive lane, which of four sampling instants inside a bit period gives a clean capture. The block runs on a clock at four times the bit rate, so each clock edge is one of the four sampling phases of the current bit. A slower frame clock marks frame boundaries: its rising edge starts a frame of 4, 7 or 8 bits, chosen by a mode input. The rising edge resets the sampling grid, so the edge where the frame clock is first seen high is phase 0 of bit slot 0.

To align the lanes, the surrounding logic raises a deskew request and sends a fixed training frame on every lane for several frames. The block checks each phase of each lane against the training frame. When the request drops, each lane keeps its best phase, or reports an error and keeps its earlier choice. The selection then holds until the next request. Between calibrations every lane delivers a retimed bit taken at its selected phase.

Top module: `dsk_phase_align`

## Requirements
- R1: After reset, with a mode other than the 4-bit mode, every lane reports sampling phase 2, and its calibrated flag, error flag and retimed bit are all 0.
- R2: The sampling phase of a clock edge is the number of edges since the frame clock was last seen rising, modulo 4. The bit slot is that count divided by 4. The retimed bit of a lane takes the lane input on the edge whose phase equals the lane's reported phase, and holds it until the next such edge.
- R3: The deskew request is sampled only on the edge where the frame clock is first seen low. A captured request starts calibration at the next frame start. A request that is high only while the frame clock is high starts nothing.
- R4: Mode encoding: 0 gives 4-bit frames, 1 gives 7-bit frames, and 2 or 3 give 8-bit frames. During calibration, bit slot s of a frame of M bits is expected to be 1 when s is at least (M+1)/2, and 0 otherwise. Slot 0 is the first slot after the frame start. This gives 0011, 0000111 and 00001111.
- R5: A phase of a lane passes only if every sample it took during every calibration frame matched the expected bit.
- R6: From the passing phases, the block computes mid = (lowest + highest) / 2, rounded down. The lane selects mid if mid passed, and otherwise the lowest passing phase.
- R7: If no phase of a lane passed, calibration ends with that lane's phase unchanged, its error flag set and its calibrated flag clear. The two flags are never set together.
- R8: Calibration ends at the first frame start after a frame-clock fall that sampled the request low. Fewer than 3 complete calibration frames count as a failure, handled as in R7.
- R9: A lane's phase changes only when a calibration ends, and a new lane input pattern between calibrations leaves it unchanged. Both flags clear when a calibration begins and change otherwise only when a calibration ends.
- R10: In the 4-bit mode every lane reports phase 2. A calibration then ends with the calibrated flag set and the error flag clear, whatever the data and the number of frames, and the stored phase is kept.
- R11: Each lane selects its phase from its own samples, so lanes with different delays settle on different phases in the same calibration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, four edges per bit |
| rst | input | 1 | Synchronous active-high reset |
| frame_clk | input | 1 | Frame clock, sampled on clk; its rise starts a frame |
| deskew_req | input | 1 | Calibration request, captured when frame_clk falls |
| mode | input | 2 | Bits per frame: 0 = 4, 1 = 7, 2 or 3 = 8 |
| rx_ser | input | CH | Serial lane inputs |
| phase_sel | output | 2*CH | Reported sampling phase, two bits per lane (lane c at bits 2c+1:2c) |
| rx_bit | output | CH | Retimed bit per lane |
| cal_ok | output | CH | Lane calibrated successfully |
| cal_err | output | CH | Lane failed its last calibration |

## Verification
The bench delays each lane by 0 to 3 samples, so the passing set is the run from the delay up to phase 3. A design that keyed the pattern to the wrong slot, or ignored the prior frame's last bit, would pick the wrong centre. Injected glitches punch holes in that run. A centre that lands on a failed phase must give way to the lowest passing phase, and a lane with every phase hit must report an error without disturbing its stored phase. Two-frame calibrations, request pulses that end before the frame clock falls, and the 4-bit bypass target a design that counts frames loosely, samples the request on the wrong edge, or lets pattern data leak into the fixed phase. Retimed bits are then compared against the exact sample driven at the selected phase.

// File: rtl/dsk_pkg.sv
package dsk_pkg;
    localparam int PH_N   = 4;
    localparam int PH_W   = $clog2(PH_N);
    localparam int SLOT_W = 3;

    typedef logic [PH_W-1:0]   phase_t;
    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [PH_N-1:0]   phmask_t;

    typedef enum logic [1:0] {
        MODE_X4  = 2'd0,
        MODE_X7  = 2'd1,
        MODE_X8  = 2'd2,
        MODE_X8B = 2'd3
    } mode_e;

    localparam phase_t DEF_PHASE = 2'd2;

    typedef struct packed {
        phase_t ph;
        logic   exp_bit;
        logic   active;
        logic   enter;
        logic   finish;
        logic   enough;
        logic   bypass;
    } tick_t;

    function automatic logic [3:0] frame_bits(mode_e m);
        case (m)
            MODE_X4: return 4'd4;
            MODE_X7: return 4'd7;
            default: return 4'd8;
        endcase
    endfunction

    function automatic logic train_bit(mode_e m, slot_t s);
        logic [3:0] half;
        half = (frame_bits(m) + 4'd1) >> 1;
        return {1'b0, s} >= half;
    endfunction

    function automatic phase_t pick_phase(phmask_t ok);
        phase_t lo, hi, mid;
        logic   seen;
        logic [PH_W:0] sum;
        lo = '0; hi = '0; seen = 1'b0;
        for (int p = 0; p < PH_N; p++) begin
            if (ok[p]) begin
                if (!seen) lo = PH_W'(p);
                hi   = PH_W'(p);
                seen = 1'b1;
            end
        end
        sum = {1'b0, lo} + {1'b0, hi};
        mid = sum[PH_W:1];
        return ok[mid] ? mid : lo;
    endfunction
endpackage

// File: rtl/dsk_frame_ctl.sv
module dsk_frame_ctl
    import dsk_pkg::*;
#(
    parameter int MIN_FRAMES = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  frame_clk,
    input  logic  deskew_req,
    input  mode_e mode,
    output tick_t tk
);
    localparam int NF_W = $clog2(MIN_FRAMES + 1);
    localparam logic [NF_W-1:0] NF_MAX = NF_W'(MIN_FRAMES);

    logic            fclk_q, req_q, cal_q;
    logic [NF_W-1:0] nfr_q, nfr_nx;
    phase_t          ph_q, cur_ph;
    slot_t           slot_q, cur_slot;
    logic            rise, fall, last_slot;

    assign rise      = frame_clk & ~fclk_q;
    assign fall      = ~frame_clk & fclk_q;
    assign cur_ph    = rise ? '0 : ph_q;
    assign cur_slot  = rise ? '0 : slot_q;
    assign last_slot = ({1'b0, cur_slot} == frame_bits(mode) - 4'd1);
    assign nfr_nx    = (nfr_q == NF_MAX) ? NF_MAX : nfr_q + 1'b1;

    always_comb begin
        tk.ph      = cur_ph;
        tk.exp_bit = train_bit(mode, cur_slot);
        tk.enter   = rise & req_q & ~cal_q;
        tk.finish  = rise & cal_q & ~req_q;
        tk.active  = tk.enter | (cal_q & ~tk.finish);
        tk.enough  = (nfr_nx >= NF_MAX);
        tk.bypass  = (mode == MODE_X4);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fclk_q <= 1'b0;
            req_q  <= 1'b0;
            cal_q  <= 1'b0;
            nfr_q  <= '0;
            ph_q   <= '0;
            slot_q <= '0;
        end else begin
            fclk_q <= frame_clk;
            if (fall) req_q <= deskew_req;
            ph_q <= cur_ph + 1'b1;
            if (cur_ph == phase_t'(PH_N - 1))
                slot_q <= last_slot ? '0 : cur_slot + 1'b1;
            else
                slot_q <= cur_slot;
            if (tk.enter) begin
                cal_q <= 1'b1;
                nfr_q <= '0;
            end else if (tk.finish) begin
                cal_q <= 1'b0;
            end else if (rise && cal_q) begin
                nfr_q <= nfr_nx;
            end
        end
    end
endmodule

// File: rtl/dsk_lane.sv
module dsk_lane
    import dsk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   rx,
    input  tick_t  tk,
    output phase_t phase_out,
    output logic   bit_out,
    output logic   ok,
    output logic   err
);
    phmask_t pass_q, pass_nx;
    phase_t  sel_q;
    logic    rbit_q, ok_q, err_q;

    assign phase_out = tk.bypass ? DEF_PHASE : sel_q;
    assign bit_out   = rbit_q;
    assign ok        = ok_q;
    assign err       = err_q;

    always_comb begin
        pass_nx = tk.enter ? '1 : pass_q;
        if (tk.active && (rx != tk.exp_bit)) pass_nx[tk.ph] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pass_q <= '1;
            sel_q  <= DEF_PHASE;
            rbit_q <= 1'b0;
            ok_q   <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (tk.active) pass_q <= pass_nx;
            if (tk.ph == phase_out) rbit_q <= rx;
            if (tk.enter) begin
                ok_q  <= 1'b0;
                err_q <= 1'b0;
            end else if (tk.finish) begin
                if (tk.bypass) begin
                    ok_q <= 1'b1;
                end else if ((|pass_q) && tk.enough) begin
                    sel_q <= pick_phase(pass_q);
                    ok_q  <= 1'b1;
                end else begin
                    err_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dsk_phase_align.sv
module dsk_phase_align
    import dsk_pkg::*;
#(
    parameter int CH         = 4,
    parameter int MIN_FRAMES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_clk,
    input  logic              deskew_req,
    input  logic [1:0]        mode,
    input  logic [CH-1:0]     rx_ser,
    output logic [2*CH-1:0]   phase_sel,
    output logic [CH-1:0]     rx_bit,
    output logic [CH-1:0]     cal_ok,
    output logic [CH-1:0]     cal_err
);
    tick_t tk;
    logic  cal_fin, cal_go;

    dsk_frame_ctl #(.MIN_FRAMES(MIN_FRAMES)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .frame_clk  (frame_clk),
        .deskew_req (deskew_req),
        .mode       (mode_e'(mode)),
        .tk         (tk)
    );

    assign cal_fin = tk.finish;
    assign cal_go  = tk.enter;

    for (genvar c = 0; c < CH; c++) begin : g_lane
        dsk_lane u_lane (
            .clk       (clk),
            .rst       (rst),
            .rx        (rx_ser[c]),
            .tk        (tk),
            .phase_out (phase_sel[2*c +: 2]),
            .bit_out   (rx_bit[c]),
            .ok        (cal_ok[c]),
            .err       (cal_err[c])
        );
    end
endmodule

// File: rtl/dsk_phase_align_chk.sv
module dsk_phase_align_chk #(
    parameter int CH = 4
) (
    input logic            clk,
    input logic            rst,
    input logic [1:0]      mode,
    input logic [2*CH-1:0] phase_sel,
    input logic [CH-1:0]   cal_ok,
    input logic [CH-1:0]   cal_err,
    input logic            cal_fin,
    input logic            cal_go
);
    for (genvar c = 0; c < CH; c++) begin : g_ck
        // R7: a lane is never both calibrated and failed
        p_flags_excl_r7: assert property (@(posedge clk) disable iff (rst)
            !(cal_ok[c] && cal_err[c]));
    end

    // R10: bypass mode reports the fixed phase on every lane
    p_bypass_phase_r10: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0) |-> (phase_sel == {CH{2'd2}}));

    // R9: selection holds unless a calibration ends or the mode moves
    p_hold_sel_r9: assert property (@(posedge clk) disable iff (rst)
        !cal_fin |=> ($stable(phase_sel) || $changed(mode)));

    // R9: flags change only at calibration entry or exit
    p_flags_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !(cal_fin || cal_go) |=> ($stable(cal_ok) && $stable(cal_err)));

    // R9: entering calibration clears both flags
    p_entry_clear_r9: assert property (@(posedge clk) disable iff (rst)
        cal_go |=> (cal_ok == '0 && cal_err == '0));
endmodule

bind dsk_phase_align dsk_phase_align_chk #(.CH(CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .phase_sel (phase_sel),
    .cal_ok    (cal_ok),
    .cal_err   (cal_err),
    .cal_fin   (cal_fin),
    .cal_go    (cal_go)
);

// File: tb/sim_dsk_phase_align.sv
module sim_dsk_phase_align;
    localparam int CH = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            frame_clk = 1'b0;
    logic            deskew_req = 1'b0;
    logic [1:0]      mode = 2'd2;
    logic [CH-1:0]   rx_ser = '0;
    logic [2*CH-1:0] phase_sel;
    logic [CH-1:0]   rx_bit, cal_ok, cal_err;

    always #2 clk = ~clk;

    dsk_phase_align #(.CH(CH)) u0 (
        .clk(clk), .rst(rst), .frame_clk(frame_clk), .deskew_req(deskew_req),
        .mode(mode), .rx_ser(rx_ser), .phase_sel(phase_sel), .rx_bit(rx_bit),
        .cal_ok(cal_ok), .cal_err(cal_err)
    );

    int n_chk = 0, n_bad = 0;
    int skew [CH];
    logic [3:0] gmask [CH];
    int   exp_sel [CH];
    logic exp_ok [CH], exp_err [CH], last_bit [CH];
    logic pend = 1'b0;
    int   pend_ph = 0;
    logic drv [CH];

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int frame_len();
        return (mode == 2'd0) ? 4 : (mode == 2'd1) ? 7 : 8;
    endfunction

    function automatic int eff_phase(int c);
        return (mode == 2'd0) ? 2 : exp_sel[c];
    endfunction

    function automatic int centre_pick(logic [3:0] m);
        int first = -1, last = -1, mid;
        for (int p = 0; p < 4; p++)
            if (m[p]) begin
                if (first < 0) first = p;
                last = p;
            end
        mid = (first + last) / 2;
        return m[mid] ? mid : first;
    endfunction

    task automatic flush_pending();
        if (pend)
            for (int c = 0; c < CH; c++)
                if (pend_ph == eff_phase(c))
                    check("R2 retimed bit", int'(rx_bit[c]), int'(drv[c]));
        pend = 1'b0;
    endtask

    task automatic run_frame(bit req, bit pulse, bit pat, bit glitch, bit chk);
        int M;
        logic fb [CH][8];
        M = frame_len();
        for (int c = 0; c < CH; c++)
            for (int s = 0; s < 8; s++)
                fb[c][s] = pat ? logic'(s >= (M + 1) / 2) : logic'($urandom % 2);
        for (int t = 0; t < 4 * M; t++) begin
            @(negedge clk);
            flush_pending();
            frame_clk = (t < 2 * M);
            if (t == 0) deskew_req = req;
            if (pulse && t == M) deskew_req = 1'b0;
            for (int c = 0; c < CH; c++) begin
                int k;
                logic v;
                k = t - skew[c];
                v = (k < 0) ? last_bit[c] : fb[c][k / 4];
                if (glitch && t >= 4 && t < 8 && gmask[c][t - 4]) v = ~v;
                rx_ser[c] = v;
                drv[c] = v;
            end
            pend = chk;
            pend_ph = t % 4;
        end
        for (int c = 0; c < CH; c++) last_bit[c] = fb[c][M - 1];
    endtask

    task automatic check_status(string tag);
        for (int c = 0; c < CH; c++) begin
            check({tag, " phase"}, int'(phase_sel[2*c +: 2]), eff_phase(c));
            check({tag, " ok"}, int'(cal_ok[c]), int'(exp_ok[c]));
            check({tag, " err"}, int'(cal_err[c]), int'(exp_err[c]));
        end
    endtask

    // K calibration frames, then a closing frame and two retimed-data frames
    task automatic do_cal(int K, string tag);
        run_frame(1, 0, 1, 0, 0);
        for (int i = 1; i <= K; i++) run_frame(i < K, 0, 1, i == 1, 0);
        run_frame(0, 0, 0, 0, 0);
        for (int c = 0; c < CH; c++) begin
            logic [3:0] m;
            m = 4'b0;
            for (int p = 0; p < 4; p++) m[p] = (p >= skew[c]);
            m = m & ~gmask[c];
            if (mode == 2'd0) begin
                exp_ok[c] = 1'b1; exp_err[c] = 1'b0;
            end else if (m != 4'b0 && K >= 3) begin
                exp_sel[c] = centre_pick(m);
                exp_ok[c] = 1'b1; exp_err[c] = 1'b0;
            end else begin
                exp_ok[c] = 1'b0; exp_err[c] = 1'b1;
            end
        end
        check_status(tag);
        run_frame(0, 0, 0, 0, 1);
        run_frame(0, 0, 0, 0, 1);
    endtask

    task automatic set_lanes(int d0, int d1, int d2, int d3,
                             logic [3:0] g0, logic [3:0] g1, logic [3:0] g2, logic [3:0] g3);
        skew[0] = d0; skew[1] = d1; skew[2] = d2; skew[3] = d3;
        gmask[0] = g0; gmask[1] = g1; gmask[2] = g2; gmask[3] = g3;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got 0 expected 1 (run completed)");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20417));
        for (int c = 0; c < CH; c++) begin
            exp_sel[c] = 2; exp_ok[c] = 0; exp_err[c] = 0; last_bit[c] = 0;
            skew[c] = 0; gmask[c] = 4'b0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check_status("R1 reset");
        for (int c = 0; c < CH; c++) check("R1 rx_bit", int'(rx_bit[c]), 0);

        // R11 R6 R4: four delays in 8-bit mode give phases 1,2,2,3
        mode = 2'd2;
        set_lanes(0, 1, 2, 3, 4'b0, 4'b0, 4'b0, 4'b0);
        do_cal(3, "R11 per-lane");

        // R6 fallback, R7 failure, R5 single glitch, 7-bit mode
        mode = 2'd1;
        set_lanes(0, 0, 1, 3, 4'b0010, 4'b1111, 4'b0100, 4'b1000);
        do_cal(4, "R6 R7 R5 glitch");

        // R9: next calibration clears the error; R4 in 4-bit frames comes later
        mode = 2'd2;
        set_lanes(3, 2, 1, 0, 4'b0, 4'b0, 4'b0, 4'b0);
        do_cal(3, "R9 reclear");

        // R8: two frames are too few
        set_lanes(0, 0, 0, 0, 4'b0, 4'b0, 4'b0, 4'b0);
        do_cal(2, "R8 short");

        // R3: request pulse gone before the frame clock falls; R9 new skew ignored
        set_lanes(3, 3, 3, 3, 4'b0, 4'b0, 4'b0, 4'b0);
        run_frame(1, 1, 1, 0, 0);
        for (int i = 0; i < 4; i++) run_frame(0, 0, 1, 0, 0);
        check_status("R3 R9 ignored");

        // R10: 4-bit bypass, then back to 8-bit shows the stored phase
        mode = 2'd0;
        set_lanes(3, 1, 0, 2, 4'b1111, 4'b0, 4'b0, 4'b0);
        do_cal(2, "R10 bypass");
        mode = 2'd2;
        run_frame(0, 0, 0, 0, 1);
        check_status("R10 stored");

        // random calibrations, R5 R6 R7 R8 R11
        for (int r = 0; r < 16; r++) begin
            int K;
            mode = 2'($urandom % 3);
            for (int c = 0; c < CH; c++) begin
                skew[c] = $urandom % 4;
                gmask[c] = ($urandom % 4 == 0) ? 4'($urandom % 16) : 4'b0;
            end
            K = 2 + $urandom % 3;
            do_cal(K, "R5 R6 R11 random");
        end
        @(negedge clk);
        flush_pending();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule